// File: doc/BRIEF.md
# LCD Panel Status Bit Generator

When a flat panel is driven in place of a tube display, there is no real retrace for polling software to wait on. This block makes up the two status bits that such software reads: a display-enable bit and a vertical-sync bit. A set display-enable bit tells the host that it may access video memory.

The block can run in one of two ways.
- **Toggle mode.** Display-enable alternates on a fixed count of character clocks. Vertical-sync is raised only on the opening scanline of a frame.
- **Window mode.** Display-enable covers an early stretch of every scanline and also a band of rows at the bottom of the panel. Vertical-sync covers a fixed group of rows. The row positions differ between text and graphics layouts.

The surrounding timing logic supplies four single-cycle pulses: character tick, scanline start, character-row start and frame start. The block keeps its own position counters from these pulses. The mode bit and the text/graphics flag are taken only at the start of a scanline.

Top module: `lcd_status_gen`

## Requirements
- R1: While `rst` is high, both `disp_en` and `vsync` read 0 in the following cycle. Reset leaves the block at the start of a scanline on row 0, not on a frame's first line, in toggle mode with the text layout.
- R2: Toggle mode (`stat_mode`=0): after a scanline start, `disp_en` is 1 for the first 16 character ticks. It is 0 for the next 16, and keeps alternating every 16 ticks.
- R3: Toggle mode: `vsync` is 1 from a frame start until the next scanline start, and 0 on every other scanline.
- R4: Window mode (`stat_mode`=1): `disp_en` is 1 from a scanline start until the 16th character tick of that scanline.
- R5: Window mode, text layout (`gfx_sel`=0): `disp_en` is 1 on every scanline whose row count is 22 or more.
- R6: Window mode, graphics layout (`gfx_sel`=1): `disp_en` is 1 on every scanline whose row count is 85 or more.
- R7: Window mode, text layout: `vsync` is 1 exactly while the row count equals 24.
- R8: Window mode, graphics layout: `vsync` is 1 exactly while the row count is in 93 to 96 inclusive.
- R9: `stat_mode` and `gfx_sel` are captured only in a cycle with `line_start` or `frame_start`. Changes at any other time have no effect until the next such cycle.
- R10: Both outputs are registered. They reflect every pulse given in a cycle from the next cycle on. A `char_tick` in the same cycle as a scanline start or frame start is not counted.
- R11: `frame_start` sets the row count to 0 and also acts as a scanline start. It overrides a `row_start` given in the same cycle.
- R12: Each `row_start` adds one to the row count. The count stops at 127 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| char_tick | input | 1 | One character clock elapsed |
| line_start | input | 1 | A new scanline begins |
| row_start | input | 1 | A new character row begins |
| frame_start | input | 1 | A new frame begins (row 0, first scanline) |
| gfx_sel | input | 1 | 1 = graphics layout, 0 = text layout |
| stat_mode | input | 1 | 0 = toggle mode, 1 = window mode |
| disp_en | output | 1 | Display-enable status bit |
| vsync | output | 1 | Vertical-sync status bit |

## Verification
The bench runs the block through several kinds of frame.
- **Toggle-mode frames with back-to-back ticks and with spaced ticks.** These show that the 16-tick alternation follows ticks and not cycles.
- **Text and graphics frames in window mode.** These run far enough to cross rows 22, 24, 85 and 93 to 96, which separates the two threshold sets and the inclusive edges of the sync band.
- **A mid-line mode flip, a frame start coinciding with row and tick pulses, and a 140-row frame.** These isolate the sampling point, the precedence of frame start and the saturation of the row count.
- **A reset in mid-frame.** This shows that reset returns the block to its defined state.

// File: rtl/lcdstat_pkg.sv
package lcdstat_pkg;
  typedef enum logic {
    STAT_TOGGLE = 1'b0,
    STAT_WINDOW = 1'b1
  } stat_mode_e;

  typedef struct packed {
    logic       gfx;
    stat_mode_e mode;
  } line_cfg_t;
endpackage

// File: rtl/lcdstat_char_timer.sv
module lcdstat_char_timer #(
  parameter int WIN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  output logic nxt_phase,
  output logic nxt_early
);
  localparam int SUB_W = (WIN > 2) ? $clog2(WIN) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(WIN - 1);

  logic [SUB_W-1:0] sub_q, sub_d;
  logic             phase_q, early_q;

  always_comb begin
    sub_d     = sub_q;
    nxt_phase = phase_q;
    nxt_early = early_q;
    if (restart) begin
      sub_d     = '0;
      nxt_phase = 1'b0;
      nxt_early = 1'b1;
    end else if (tick) begin
      if (sub_q == SUB_LAST) begin
        sub_d     = '0;
        nxt_phase = ~phase_q;
        nxt_early = 1'b0;
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q   <= '0;
      phase_q <= 1'b0;
      early_q <= 1'b1;
    end else begin
      sub_q   <= sub_d;
      phase_q <= nxt_phase;
      early_q <= nxt_early;
    end
  end

  // R2: the alternation only moves on a character tick
  a_r2_phase_hold: assert property (@(posedge clk) disable iff (rst)
    (!restart && !tick) |=> $stable(phase_q));
  // R4: the early window, once closed, stays closed until a scanline start
  a_r4_early_once: assert property (@(posedge clk) disable iff (rst)
    (!restart && !early_q) |=> !early_q);
endmodule

// File: rtl/lcdstat_row_tracker.sv
module lcdstat_row_tracker #(
  parameter int ROW_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             line_start,
  input  logic             row_start,
  output logic [ROW_W-1:0] nxt_row,
  output logic             nxt_first
);
  localparam logic [ROW_W-1:0] ROW_MAX = {ROW_W{1'b1}};

  logic [ROW_W-1:0] row_q;
  logic             first_q;

  always_comb begin
    nxt_row   = row_q;
    nxt_first = first_q;
    if (frame_start) begin
      nxt_row   = '0;
      nxt_first = 1'b1;
    end else begin
      if (line_start)
        nxt_first = 1'b0;
      if (row_start && row_q != ROW_MAX)
        nxt_row = row_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q   <= '0;
      first_q <= 1'b0;
    end else begin
      row_q   <= nxt_row;
      first_q <= nxt_first;
    end
  end

  // R12: the row count never wraps past its top value
  a_r12_row_sat: assert property (@(posedge clk) disable iff (rst)
    (row_q == ROW_MAX && !frame_start) |=> row_q == ROW_MAX);
  // R11: a frame start always lands on row 0
  a_r11_frame_row0: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> row_q == '0);
  // R3: the first-line flag can only come from a frame start
  a_r3_first_src: assert property (@(posedge clk) disable iff (rst)
    $rose(first_q) |-> $past(frame_start));
endmodule

// File: rtl/lcd_status_gen.sv
module lcd_status_gen #(
  parameter int WIN          = 16,
  parameter int ROW_W        = 7,
  parameter int TXT_DE_ROW   = 22,
  parameter int GFX_DE_ROW   = 85,
  parameter int TXT_VS_FIRST = 24,
  parameter int TXT_VS_LAST  = 24,
  parameter int GFX_VS_FIRST = 93,
  parameter int GFX_VS_LAST  = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic char_tick,
  input  logic line_start,
  input  logic row_start,
  input  logic frame_start,
  input  logic gfx_sel,
  input  logic stat_mode,
  output logic disp_en,
  output logic vsync
);
  import lcdstat_pkg::*;

  localparam logic [ROW_W-1:0] TDE = ROW_W'(TXT_DE_ROW);
  localparam logic [ROW_W-1:0] GDE = ROW_W'(GFX_DE_ROW);
  localparam logic [ROW_W-1:0] TV0 = ROW_W'(TXT_VS_FIRST);
  localparam logic [ROW_W-1:0] TV1 = ROW_W'(TXT_VS_LAST);
  localparam logic [ROW_W-1:0] GV0 = ROW_W'(GFX_VS_FIRST);
  localparam logic [ROW_W-1:0] GV1 = ROW_W'(GFX_VS_LAST);

  logic             line_any;
  logic             nxt_phase, nxt_early, nxt_first;
  logic [ROW_W-1:0] nxt_row;
  line_cfg_t        cfg_q, cfg_d;
  logic             de_d, vs_d, de_q, vs_q;

  assign line_any = line_start | frame_start;

  lcdstat_char_timer #(.WIN(WIN)) u_char (
    .clk(clk), .rst(rst), .restart(line_any), .tick(char_tick),
    .nxt_phase(nxt_phase), .nxt_early(nxt_early)
  );

  lcdstat_row_tracker #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
    .row_start(row_start), .nxt_row(nxt_row), .nxt_first(nxt_first)
  );

  always_comb begin
    cfg_d = cfg_q;
    if (line_any) begin
      cfg_d.gfx  = gfx_sel;
      cfg_d.mode = stat_mode_e'(stat_mode);
    end
  end

  always_comb begin
    if (cfg_d.mode == STAT_TOGGLE) begin
      de_d = ~nxt_phase;
      vs_d = nxt_first;
    end else if (cfg_d.gfx) begin
      de_d = nxt_early | (nxt_row >= GDE);
      vs_d = (nxt_row >= GV0) && (nxt_row <= GV1);
    end else begin
      de_d = nxt_early | (nxt_row >= TDE);
      vs_d = (nxt_row >= TV0) && (nxt_row <= TV1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '{gfx: 1'b0, mode: STAT_TOGGLE};
      de_q  <= 1'b0;
      vs_q  <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      de_q  <= de_d;
      vs_q  <= vs_d;
    end
  end

  assign disp_en = de_q;
  assign vsync   = vs_q;

  // R9: configuration only moves at a scanline or frame start
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !line_any |=> $stable(cfg_q));
  // R1: reset clears both status bits
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!de_q && !vs_q));
endmodule

// File: tb/test_lcd_status_gen.sv
`timescale 1ns/1ps
module test_lcd_status_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic char_tick = 0, line_start = 0, row_start = 0, frame_start = 0;
  logic gfx_sel = 0, stat_mode = 0;
  logic disp_en, vsync;

  always #4 clk = ~clk;

  lcd_status_gen i_lcd_status_gen (
    .clk(clk), .rst(rst), .char_tick(char_tick), .line_start(line_start),
    .row_start(row_start), .frame_start(frame_start), .gfx_sel(gfx_sel),
    .stat_mode(stat_mode), .disp_en(disp_en), .vsync(vsync)
  );

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  string seg_tag = "R1";

  // behavioural reference
  int m_cc = 0, m_row = 0;
  bit m_first = 0, m_mode = 0, m_gfx = 0, m_rst = 1;
  bit exp_de = 0, exp_vs = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cc = 0; m_row = 0; m_first = 0; m_mode = 0; m_gfx = 0; m_rst = 1;
      exp_de = 0; exp_vs = 0;
    end else begin
      m_rst = 0;
      if (frame_start) begin
        m_row = 0; m_first = 1; m_cc = 0; m_mode = stat_mode; m_gfx = gfx_sel;
      end else begin
        if (line_start) begin
          m_cc = 0; m_first = 0; m_mode = stat_mode; m_gfx = gfx_sel;
        end
        if (row_start && m_row < 127) m_row++;
        if (!line_start && char_tick) m_cc++;
      end
      if (!m_mode) begin
        exp_de = ((m_cc / 16) % 2) == 0;
        exp_vs = m_first;
      end else if (m_gfx) begin
        exp_de = (m_cc < 16) || (m_row >= 85);
        exp_vs = (m_row >= 93) && (m_row <= 96);
      end else begin
        exp_de = (m_cc < 16) || (m_row >= 22);
        exp_vs = (m_row == 24);
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      string rde, rvs;
      if (m_rst)        begin rde = "R1"; rvs = "R1"; end
      else if (!m_mode) begin rde = "R2"; rvs = "R3"; end
      else if (m_gfx)   begin rde = (m_row >= 85) ? "R6" : "R4"; rvs = "R8"; end
      else              begin rde = (m_row >= 22) ? "R5" : "R4"; rvs = "R7"; end
      n_cmp += 2;
      if (disp_en !== exp_de) begin
        n_bad++;
        $display("FAIL %s/%s disp_en row=%0d cc=%0d actual=%b expected=%b",
                 rde, seg_tag, m_row, m_cc, disp_en, exp_de);
      end
      if (vsync !== exp_vs) begin
        n_bad++;
        $display("FAIL %s/%s vsync row=%0d actual=%b expected=%b",
                 rvs, seg_tag, m_row, vsync, exp_vs);
      end
    end
  end

  task automatic drive(bit t, bit l, bit r, bit f);
    @(negedge clk);
    #1;
    char_tick = t; line_start = l; row_start = r; frame_start = f;
  endtask

  task automatic do_line(int nt, bit rowp, bit frm, int gap);
    drive(0, 1, rowp, frm);
    for (int i = 0; i < nt; i++) begin
      drive(1, 0, 0, 0);
      for (int g = 0; g < gap; g++) drive(0, 0, 0, 0);
    end
  endtask

  task automatic do_frame(int rows, int lpr, int nt, int gap);
    for (int r = 0; r < rows; r++)
      for (int l = 0; l < lpr; l++)
        do_line(nt, (l == 0) && (r > 0), (r == 0) && (l == 0), gap);
    drive(0, 0, 0, 0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1 rst = 0;
    drive(0, 0, 0, 0); drive(0, 0, 0, 0);

    // R2 R3: toggle mode, dense and spaced ticks
    seg_tag = "R2";
    stat_mode = 0; gfx_sel = 0;
    do_frame(30, 2, 40, 0);
    do_frame(10, 2, 35, 1);

    // R4 R5 R7: window mode, text rows
    seg_tag = "R5";
    stat_mode = 1; gfx_sel = 0;
    do_frame(30, 2, 40, 0);

    // R6 R8: window mode, graphics rows
    seg_tag = "R8";
    gfx_sel = 1;
    do_frame(100, 1, 36, 0);
    stat_mode = 0;
    do_frame(5, 1, 20, 0);

    // R9: mid-line change is ignored until the next scanline start
    seg_tag = "R9";
    stat_mode = 1; gfx_sel = 0;
    drive(0, 1, 0, 1);
    repeat (3) drive(1, 0, 0, 0);
    #1 stat_mode = 0; gfx_sel = 1;
    repeat (30) drive(1, 0, 0, 0);
    do_line(40, 1, 0, 0);
    drive(0, 0, 0, 0);

    // R10 R11: frame start with row, line and tick pulses together
    seg_tag = "R11";
    stat_mode = 1; gfx_sel = 0;
    do_frame(25, 1, 10, 0);
    drive(1, 1, 1, 1);
    drive(1, 0, 0, 0);
    seg_tag = "R10";
    drive(1, 1, 0, 0);
    repeat (20) drive(1, 0, 0, 0);

    // R12: row count saturates
    seg_tag = "R12";
    gfx_sel = 1;
    do_frame(140, 1, 18, 0);
    repeat (5) do_line(4, 1, 0, 0);
    drive(0, 0, 0, 0);

    // R1: reset in mid-frame
    seg_tag = "R1";
    do_line(10, 1, 0, 0);
    #1 rst = 1;
    drive(1, 0, 0, 0); drive(0, 0, 0, 0);
    #1 rst = 0;
    repeat (20) drive(1, 0, 0, 0);
    drive(0, 0, 0, 0);

    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule